// File: doc/BRIEF.md
# Clock-Distributor Configuration Sequencer

This block sets up an external clock-distribution device through a four-wire serial port: a serial clock, an active-low enable, a data line towards the device and a data line back from it. It also drives the device's active-low power-down and sync pins. A write request sends a complete set of nine 28-bit register values to the device. The select input picks one of two tables, one for the primary reference and one for the secondary reference. Both tables are parameters of the block.

Besides the full write, the block can do two other operations. A read operation fetches one register from the device and compares the 28 bits it gets back with the table entry for that register. A difference sets a sticky mismatch flag. A reset operation steps the power-down and sync pins through their fixed sequence. A busy/done handshake brackets every operation. The serial clock speed is set by a divider input, counted in system clocks.

Top module: `clkdist_cfg_seq`

## Requirements
- R1: After reset, and in every cycle where `busy` is low, `dev_cs_n`, `dev_pd_n` and `dev_sync_n` are high, `dev_sclk` and `dev_mosi` are low, and `done` and `mismatch` come out of reset low.
- R2: An accepted write request sends nine frames, for registers 0 to 8 in ascending order. Each frame is the 28-bit table value placed in bits 31:4, with the register index in bits 3:0. When `sel_sec`=0 at the request, the values come from `TBL_PRI`. When `sel_sec`=1, they come from `TBL_SEC`. Entry i of a table occupies bits [28*i+27 : 28*i].
- R3: Each frame holds `dev_cs_n` low for exactly 32 rising edges of `dev_sclk`, and the bits go out least-significant first. `dev_cs_n` returns high after the 32nd bit and stays high between frames. `dev_sclk` is low whenever `dev_cs_n` is high.
- R4: `dev_mosi` changes only while `dev_sclk` is low. Within a frame, each high phase and each low phase of `dev_sclk` lasts `rate_div` system clocks, and a `rate_div` of 0 behaves as 1.
- R5: A read sends two frames. The first is a command frame with `rd_idx` in bits 7:4, the code 0xE in bits 3:0 and zeros above. The second is a capture frame with `dev_mosi` held low. In the capture frame, `dev_miso` is sampled at each rising `dev_sclk`, least-significant bit first. `rd_value` is set to captured bits 31:4, and the low four bits are dropped.
- R6: At the end of a read, `mismatch` is set if `rd_value` differs from the table entry selected by `sel_sec` and `rd_idx`. `mismatch` then stays set and clears only in the cycle after a write request is accepted.
- R7: A reset operation drives `dev_pd_n` low for `WAIT_CYC` cycles and then holds it high for `WAIT_CYC` cycles. Next, `dev_sync_n` goes low for `WAIT_CYC` cycles, followed by `WAIT_CYC` more cycles before `done`. `dev_cs_n` stays high throughout, and `dev_pd_n` and `dev_sync_n` are never low at the same time.
- R8: `busy` rises in the cycle after an accepted request and stays high until the operation ends. For a frame operation, the end comes after the last frame, with `dev_cs_n` high. At the end, `done` is high for exactly one cycle while `busy` is low.
- R9: Requests that arrive while `busy` is high have no effect. When requests arrive together in idle, the order of precedence is write, then read, then reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_sec | input | 1 | Table select captured at a request: 0 primary, 1 secondary |
| wr_req | input | 1 | Request a full nine-register write |
| rd_req | input | 1 | Request a read and compare of one register |
| rd_idx | input | 4 | Register index for a read; indices 9 to 15 compare against zero |
| rst_req | input | 1 | Request the power-down/sync sequence |
| rate_div | input | DIVW | Serial clock half period in system clocks |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| mismatch | output | 1 | Sticky read-back compare failure |
| rd_value | output | DW | Last 28-bit value read back |
| dev_sclk | output | 1 | Serial clock to the device |
| dev_cs_n | output | 1 | Active-low serial enable |
| dev_mosi | output | 1 | Serial data to the device |
| dev_miso | input | 1 | Serial data from the device |
| dev_pd_n | output | 1 | Active-low power-down |
| dev_sync_n | output | 1 | Active-low sync |

## Verification
The bench models the device at the pins. It rebuilds every frame from the rising serial clock edges and answers read commands with a deliberately non-zero low nibble, so a design that kept those four bits or captured the bits in the wrong order returns the wrong `rd_value`. It measures each serial clock phase with dividers of 0, 1 and 3, which exposes an off-by-one in the divider or a data change while the clock is high. A corrupted reply is followed by a clean read and then a write, to show that the mismatch flag holds through the clean read and clears only on the write. Requests are also fired together and in the middle of a write: a design that obeyed them would send extra frames or pull power-down low. The reset sequence is timed phase by phase, so swapped pins or wrong wait lengths show up.

// File: rtl/clkdist_cfg_pkg.sv
package clkdist_cfg_pkg;

    // register index width inside a frame, and read command code
    localparam int IDX_W = 4;
    localparam logic [IDX_W-1:0] RD_CODE = 4'hE;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LO,
        PH_HI
    } sh_state_e;

    typedef enum logic [2:0] {
        C_IDLE,
        C_WR_GO,
        C_WR_WAIT,
        C_RC_GO,
        C_RC_WAIT,
        C_CAP_GO,
        C_CAP_WAIT,
        C_RST
    } ctl_state_e;

endpackage

// File: rtl/clkdist_lut.sv
module clkdist_lut #(
    parameter int NREG = 9,
    parameter int DW   = 28,
    parameter int IDXW = 4,
    parameter logic [NREG*DW-1:0] TBL_A = '0,
    parameter logic [NREG*DW-1:0] TBL_B = '0
) (
    input  logic            sel,
    input  logic [IDXW-1:0] idx,
    output logic [DW-1:0]   val
);

    logic [DW-1:0] ent_a [NREG];
    logic [DW-1:0] ent_b [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign ent_a[g] = TBL_A[g*DW +: DW];
        assign ent_b[g] = TBL_B[g*DW +: DW];
    end

    always_comb begin
        val = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx == IDXW'(i)) begin
                val = sel ? ent_b[i] : ent_a[i];
            end
        end
    end

endmodule

// File: rtl/clkdist_shift.sv
module clkdist_shift
    import clkdist_cfg_pkg::*;
#(
    parameter int FW   = 32,
    parameter int DROP = 4,
    parameter int DIVW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [FW-1:0]      frame,
    input  logic [DIVW-1:0]    half_div,
    input  logic               miso,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    output logic [FW-DROP-1:0] rx_hi,
    output logic               fin
);

    localparam int CW = $clog2(FW);
    localparam int RW = FW - DROP;

    typedef struct packed {
        sh_state_e       st;
        logic [DIVW-1:0] cnt;
        logic [CW-1:0]   bitn;
        logic [FW-1:0]   sh;
        logic [RW-1:0]   rx;
        logic            sclk;
        logic            cs_n;
        logic            fin;
    } sh_t;

    sh_t q, d;
    logic [DIVW-1:0] lim_m1;

    assign lim_m1 = (half_div == '0) ? '0 : half_div - 1'b1;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        unique case (q.st)
            PH_IDLE: begin
                if (go) begin
                    d.sh   = frame;
                    d.cs_n = 1'b0;
                    d.sclk = 1'b0;
                    d.cnt  = '0;
                    d.bitn = '0;
                    d.rx   = '0;
                    d.st   = PH_LO;
                end
            end
            PH_LO: begin
                if (q.cnt == lim_m1) begin
                    d.sclk = 1'b1;
                    d.cnt  = '0;
                    d.rx   = {miso, q.rx[RW-1:1]};
                    d.st   = PH_HI;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_HI: begin
                if (q.cnt == lim_m1) begin
                    d.sclk = 1'b0;
                    d.cnt  = '0;
                    if (q.bitn == CW'(FW-1)) begin
                        d.cs_n = 1'b1;
                        d.sh   = '0;
                        d.fin  = 1'b1;
                        d.st   = PH_IDLE;
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                        d.sh   = q.sh >> 1;
                        d.st   = PH_LO;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= PH_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk  = q.sclk;
    assign cs_n  = q.cs_n;
    assign mosi  = q.sh[0];
    assign rx_hi = q.rx;
    assign fin   = q.fin;

endmodule

// File: rtl/clkdist_ctrl.sv
module clkdist_ctrl
    import clkdist_cfg_pkg::*;
#(
    parameter int NREG     = 9,
    parameter int DW       = 28,
    parameter int IDXW     = 4,
    parameter int FW       = 32,
    parameter int WAIT_CYC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic            rd_req,
    input  logic            rst_req,
    input  logic            sel_in,
    input  logic [IDXW-1:0] rd_idx,
    input  logic            sh_fin,
    input  logic [DW-1:0]   sh_rx,
    input  logic [DW-1:0]   tbl_val,
    output logic            lut_sel,
    output logic [IDXW-1:0] lut_idx,
    output logic            go,
    output logic [FW-1:0]   frame,
    output logic            busy,
    output logic            done,
    output logic            mismatch,
    output logic [DW-1:0]   rd_value,
    output logic            pd_n,
    output logic            sync_n
);

    localparam int WCW = $clog2(WAIT_CYC + 1);

    typedef struct packed {
        ctl_state_e      st;
        logic [IDXW-1:0] idx;
        logic            sel;
        logic [WCW-1:0]  wcnt;
        logic [1:0]      ph;
        logic            go;
        logic [FW-1:0]   frame;
        logic            busy;
        logic            done;
        logic            mism;
        logic [DW-1:0]   rdval;
        logic            pd_n;
        logic            sync_n;
    } ctl_t;

    ctl_t q, d;

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        unique case (q.st)
            C_IDLE: begin
                if (wr_req) begin
                    d.st   = C_WR_GO;
                    d.idx  = '0;
                    d.sel  = sel_in;
                    d.busy = 1'b1;
                    d.mism = 1'b0;
                end else if (rd_req) begin
                    d.st   = C_RC_GO;
                    d.idx  = rd_idx;
                    d.sel  = sel_in;
                    d.busy = 1'b1;
                end else if (rst_req) begin
                    d.st   = C_RST;
                    d.ph   = 2'd0;
                    d.wcnt = '0;
                    d.pd_n = 1'b0;
                    d.busy = 1'b1;
                end
            end
            C_WR_GO: begin
                d.go    = 1'b1;
                d.frame = {tbl_val, q.idx};
                d.st    = C_WR_WAIT;
            end
            C_WR_WAIT: begin
                if (sh_fin) begin
                    if (q.idx == IDXW'(NREG-1)) begin
                        d.st   = C_IDLE;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.st  = C_WR_GO;
                    end
                end
            end
            C_RC_GO: begin
                d.go                   = 1'b1;
                d.frame                = '0;
                d.frame[2*IDXW-1:0]    = {q.idx, RD_CODE};
                d.st                   = C_RC_WAIT;
            end
            C_RC_WAIT: begin
                if (sh_fin) d.st = C_CAP_GO;
            end
            C_CAP_GO: begin
                d.go    = 1'b1;
                d.frame = '0;
                d.st    = C_CAP_WAIT;
            end
            C_CAP_WAIT: begin
                if (sh_fin) begin
                    d.rdval = sh_rx;
                    if (sh_rx != tbl_val) d.mism = 1'b1;
                    d.st   = C_IDLE;
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end
            C_RST: begin
                if (q.wcnt == WCW'(WAIT_CYC-1)) begin
                    d.wcnt = '0;
                    d.ph   = q.ph + 1'b1;
                    unique case (q.ph)
                        2'd0: d.pd_n   = 1'b1;
                        2'd1: d.sync_n = 1'b0;
                        2'd2: d.sync_n = 1'b1;
                        default: begin
                            d.st   = C_IDLE;
                            d.busy = 1'b0;
                            d.done = 1'b1;
                        end
                    endcase
                end else begin
                    d.wcnt = q.wcnt + 1'b1;
                end
            end
            default: d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= C_IDLE;
            q.pd_n   <= 1'b1;
            q.sync_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign lut_sel  = q.sel;
    assign lut_idx  = q.idx;
    assign go       = q.go;
    assign frame    = q.frame;
    assign busy     = q.busy;
    assign done     = q.done;
    assign mismatch = q.mism;
    assign rd_value = q.rdval;
    assign pd_n     = q.pd_n;
    assign sync_n   = q.sync_n;

endmodule

// File: rtl/clkdist_cfg_seq.sv
module clkdist_cfg_seq
    import clkdist_cfg_pkg::*;
#(
    parameter int NREG     = 9,
    parameter int DW       = 28,
    parameter int DIVW     = 8,
    parameter int WAIT_CYC = 16,
    parameter logic [NREG*DW-1:0] TBL_PRI = '0,
    parameter logic [NREG*DW-1:0] TBL_SEC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_sec,
    input  logic             wr_req,
    input  logic             rd_req,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rst_req,
    input  logic [DIVW-1:0]  rate_div,
    output logic             busy,
    output logic             done,
    output logic             mismatch,
    output logic [DW-1:0]    rd_value,
    output logic             dev_sclk,
    output logic             dev_cs_n,
    output logic             dev_mosi,
    input  logic             dev_miso,
    output logic             dev_pd_n,
    output logic             dev_sync_n
);

    localparam int FW = DW + IDX_W;

    logic             lut_sel;
    logic [IDX_W-1:0] lut_idx;
    logic [DW-1:0]    lut_val;
    logic             sh_go;
    logic [FW-1:0]    sh_frame;
    logic             sh_fin;
    logic [DW-1:0]    sh_rx;

    clkdist_lut #(
        .NREG  (NREG),
        .DW    (DW),
        .IDXW  (IDX_W),
        .TBL_A (TBL_PRI),
        .TBL_B (TBL_SEC)
    ) u_lut (
        .sel (lut_sel),
        .idx (lut_idx),
        .val (lut_val)
    );

    clkdist_ctrl #(
        .NREG     (NREG),
        .DW       (DW),
        .IDXW     (IDX_W),
        .FW       (FW),
        .WAIT_CYC (WAIT_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .rd_req   (rd_req),
        .rst_req  (rst_req),
        .sel_in   (sel_sec),
        .rd_idx   (rd_idx),
        .sh_fin   (sh_fin),
        .sh_rx    (sh_rx),
        .tbl_val  (lut_val),
        .lut_sel  (lut_sel),
        .lut_idx  (lut_idx),
        .go       (sh_go),
        .frame    (sh_frame),
        .busy     (busy),
        .done     (done),
        .mismatch (mismatch),
        .rd_value (rd_value),
        .pd_n     (dev_pd_n),
        .sync_n   (dev_sync_n)
    );

    clkdist_shift #(
        .FW   (FW),
        .DROP (IDX_W),
        .DIVW (DIVW)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (sh_go),
        .frame    (sh_frame),
        .half_div (rate_div),
        .miso     (dev_miso),
        .sclk     (dev_sclk),
        .cs_n     (dev_cs_n),
        .mosi     (dev_mosi),
        .rx_hi    (sh_rx),
        .fin      (sh_fin)
    );

endmodule

// File: rtl/clkdist_cfg_seq_chk.sv
module clkdist_cfg_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_req,
    input logic rd_req,
    input logic rst_req,
    input logic busy,
    input logic done,
    input logic mismatch,
    input logic dev_sclk,
    input logic dev_cs_n,
    input logic dev_mosi,
    input logic dev_pd_n,
    input logic dev_sync_n
);

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dev_cs_n && dev_pd_n && dev_sync_n && !dev_sclk)); // R1

    AST_SCLK_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        dev_cs_n |-> !dev_sclk); // R3

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sclk && $past(dev_sclk)) |-> $stable(dev_mosi)); // R4

    AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !(wr_req && !busy)) |=> mismatch); // R6

    AST_PD_SYNC_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_pd_n && !dev_sync_n)); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8

    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_req || rd_req || rst_req)); // R9

endmodule

bind clkdist_cfg_seq clkdist_cfg_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (wr_req),
    .rd_req     (rd_req),
    .rst_req    (rst_req),
    .busy       (busy),
    .done       (done),
    .mismatch   (mismatch),
    .dev_sclk   (dev_sclk),
    .dev_cs_n   (dev_cs_n),
    .dev_mosi   (dev_mosi),
    .dev_pd_n   (dev_pd_n),
    .dev_sync_n (dev_sync_n)
);

// File: tb/clkdist_cfg_seq_bench.sv
`timescale 1ns/1ps
module clkdist_cfg_seq_bench;

    localparam int NREG = 9;
    localparam int DW   = 28;
    localparam int DIVW = 8;
    localparam int WC   = 5;

    function automatic logic [NREG*DW-1:0] mk_tbl(input logic [DW-1:0] seed);
        logic [NREG*DW-1:0] t;
        t = '0;
        for (int i = 0; i < NREG; i++) begin
            t[i*DW +: DW] = seed ^ DW'((i + 1) * 32'h0135_7B9);
        end
        return t;
    endfunction

    localparam logic [NREG*DW-1:0] TP = mk_tbl(28'h0A5_4000);
    localparam logic [NREG*DW-1:0] TS = mk_tbl(28'h153_0020);

    function automatic logic [DW-1:0] tv(input logic s, input int i);
        return s ? TS[i*DW +: DW] : TP[i*DW +: DW];
    endfunction

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sel_sec = 1'b0;
    logic            wr_req = 1'b0;
    logic            rd_req = 1'b0;
    logic [3:0]      rd_idx = '0;
    logic            rst_req = 1'b0;
    logic [DIVW-1:0] rate_div = 8'd1;
    logic            busy, done, mismatch;
    logic [DW-1:0]   rd_value;
    logic            dev_sclk, dev_cs_n, dev_mosi, dev_miso, dev_pd_n, dev_sync_n;

    always #4 clk = ~clk;

    clkdist_cfg_seq #(
        .NREG (NREG), .DW (DW), .DIVW (DIVW), .WAIT_CYC (WC),
        .TBL_PRI (TP), .TBL_SEC (TS)
    ) u_clkdist_cfg_seq (
        .clk (clk), .rst_n (rst_n), .sel_sec (sel_sec), .wr_req (wr_req),
        .rd_req (rd_req), .rd_idx (rd_idx), .rst_req (rst_req),
        .rate_div (rate_div), .busy (busy), .done (done),
        .mismatch (mismatch), .rd_value (rd_value), .dev_sclk (dev_sclk),
        .dev_cs_n (dev_cs_n), .dev_mosi (dev_mosi), .dev_miso (dev_miso),
        .dev_pd_n (dev_pd_n), .dev_sync_n (dev_sync_n)
    );

    int nchk = 0;
    int nerr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- device model at the pins ----------------
    logic [31:0] frames [64];
    int          bitsz  [64];
    int          nfr = 0;
    logic [31:0] dev_sh = '0;
    int          dev_bits = 0;
    logic [DW-1:0] dev_reg [16];
    logic        rd_pending = 1'b0;
    logic        rd_active = 1'b0;
    logic [3:0]  rd_ix = '0;
    logic [31:0] resp = '0;
    logic        corrupt = 1'b0;
    logic        cs_prev = 1'b1;

    initial for (int i = 0; i < 16; i++) dev_reg[i] = '0;

    always @(posedge dev_sclk or dev_cs_n) begin
        if (dev_cs_n !== cs_prev) begin
            if (dev_cs_n === 1'b0) begin
                dev_bits   = 0;
                dev_sh     = '0;
                rd_active  = rd_pending;
                rd_pending = 1'b0;
                if (rd_active) resp = {dev_reg[rd_ix] ^ {{(DW-1){1'b0}}, corrupt}, 4'h5};
            end else if (dev_cs_n === 1'b1 && cs_prev === 1'b0) begin
                frames[nfr % 64] = dev_sh;
                bitsz[nfr % 64]  = dev_bits;
                nfr++;
                if (!rd_active && dev_bits == 32) begin
                    if (dev_sh[3:0] == 4'hE) begin
                        rd_pending = 1'b1;
                        rd_ix      = dev_sh[7:4];
                    end else if (dev_sh[3:0] < 4'd9) begin
                        dev_reg[dev_sh[3:0]] = dev_sh[31:4];
                    end
                end
                rd_active = 1'b0;
            end
            cs_prev = dev_cs_n;
        end else if (dev_sclk === 1'b1 && dev_cs_n === 1'b0) begin
            if (dev_bits < 32) dev_sh[dev_bits] = dev_mosi;
            dev_bits++;
        end
    end

    assign dev_miso = (rd_active && dev_bits < 32) ? resp[dev_bits[4:0]] : 1'b0;

    // ---------------- pin monitor ----------------
    int exp_div = 1;
    int rate_bad = 0;
    int mosi_viol = 0;
    int idle_viol = 0;

    always @(negedge clk) begin
        static logic p_sclk = 1'b0;
        static logic p_mosi = 1'b0;
        static int   hi_run = 0;
        static int   lo_run = 0;
        if (rst_n) begin
            if (!busy && (!dev_cs_n || dev_sclk || dev_mosi || !dev_pd_n || !dev_sync_n))
                idle_viol++;
            if (dev_sclk && p_sclk && dev_mosi !== p_mosi) mosi_viol++;
            if (dev_sclk) begin
                if (!p_sclk) begin
                    if (lo_run != exp_div) rate_bad++;
                    lo_run = 0;
                end
                hi_run++;
            end else begin
                if (p_sclk) begin
                    if (hi_run != exp_div) rate_bad++;
                    hi_run = 0;
                end
                if (!dev_cs_n) lo_run++;
                else lo_run = 0;
            end
            p_sclk = dev_sclk;
            p_mosi = dev_mosi;
        end
    end

    // ---------------- helpers ----------------
    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(done === 1'b1, "R8", "done seen", done, 1);
        chk(busy === 1'b0, "R8", "busy low with done", busy, 0);
        @(negedge clk);
        chk(done === 1'b0, "R8", "done one cycle", done, 0);
        chk(busy === 1'b0, req, "idle after op", busy, 0);
    endtask

    task automatic set_div(input int dv);
        rate_div = DIVW'(dv);
        exp_div  = (dv == 0) ? 1 : dv;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        chk(busy === 1'b0 && done === 1'b0 && mismatch === 1'b0, "R1",
            "busy/done/mismatch", {busy, done, mismatch}, 0);
        chk(dev_cs_n === 1'b1 && dev_pd_n === 1'b1 && dev_sync_n === 1'b1, "R1",
            "cs/pd/sync high", {dev_cs_n, dev_pd_n, dev_sync_n}, 3'b111);
        chk(dev_sclk === 1'b0 && dev_mosi === 1'b0, "R1", "sclk/mosi low",
            {dev_sclk, dev_mosi}, 0);
    endtask

    task automatic t_write(input logic s, input int dv);
        int base;
        set_div(dv);
        base = nfr;
        @(negedge clk);
        sel_sec = s;
        wr_req  = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        chk(busy === 1'b1, "R8", "busy after write request", busy, 1);
        chk(mismatch === 1'b0, "R6", "mismatch cleared by write", mismatch, 0);
        wait_done("R2");
        chk(nfr - base == NREG, "R2", "frame count", nfr - base, NREG);
        for (int i = 0; i < NREG; i++) begin
            chk(frames[(base + i) % 64] === {tv(s, i), 4'(i)}, "R2", "write frame",
                frames[(base + i) % 64], {tv(s, i), 4'(i)});
            chk(bitsz[(base + i) % 64] == 32, "R3", "bits per frame",
                bitsz[(base + i) % 64], 32);
        end
    endtask

    task automatic t_read(input logic s, input logic [3:0] ix, input int dv,
                          input logic bad, input logic exp_mism);
        int base;
        set_div(dv);
        corrupt = bad;
        base = nfr;
        @(negedge clk);
        sel_sec = s;
        rd_idx  = ix;
        rd_req  = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk(busy === 1'b1, "R8", "busy after read request", busy, 1);
        wait_done("R5");
        chk(nfr - base == 2, "R5", "read frame count", nfr - base, 2);
        chk(frames[base % 64] === {20'h0, ix, 4'hE}, "R5", "command frame",
            frames[base % 64], {20'h0, ix, 4'hE});
        chk(frames[(base + 1) % 64] === 32'h0, "R5", "capture frame mosi low",
            frames[(base + 1) % 64], 0);
        chk(rd_value === (tv(s, int'(ix)) ^ {{(DW-1){1'b0}}, bad}), "R5", "rd_value",
            rd_value, tv(s, int'(ix)) ^ {{(DW-1){1'b0}}, bad});
        chk(mismatch === exp_mism, "R6", "mismatch after read", mismatch, exp_mism);
        corrupt = 1'b0;
    endtask

    task automatic t_reset_seq();
        int t = 0, pd_lo = 0, sy_lo = 0, pd_last = -1, sy_first = -1, sy_last = -1;
        int cs_lo = 0, both = 0;
        @(negedge clk);
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        while (!done && t < 1000) begin
            if (!dev_pd_n) begin pd_lo++; pd_last = t; end
            if (!dev_sync_n) begin
                sy_lo++;
                if (sy_first < 0) sy_first = t;
                sy_last = t;
            end
            if (!dev_pd_n && !dev_sync_n) both++;
            if (!dev_cs_n) cs_lo++;
            @(negedge clk);
            t++;
        end
        chk(pd_lo == WC, "R7", "power-down low cycles", pd_lo, WC);
        chk(sy_lo == WC, "R7", "sync low cycles", sy_lo, WC);
        chk(sy_first - pd_last == WC + 1, "R7", "gap pd rise to sync fall",
            sy_first - pd_last, WC + 1);
        chk(t - sy_last - 1 == WC, "R7", "gap sync rise to done", t - sy_last - 1, WC);
        chk(cs_lo == 0 && both == 0, "R7", "cs high, no overlap", {cs_lo, both}, 0);
        chk(done === 1'b1 && busy === 1'b0, "R8", "reset op done", {done, busy}, 2'b10);
        @(negedge clk);
        chk(done === 1'b0, "R8", "reset done one cycle", done, 0);
    endtask

    task automatic t_busy_ignore();
        int base, pd_lo = 0, dn = 0, t = 0;
        set_div(1);
        base = nfr;
        @(negedge clk);
        sel_sec = 1'b0;
        wr_req  = 1'b1;
        rd_req  = 1'b1;
        rst_req = 1'b1;
        rd_idx  = 4'd3;
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0; rst_req = 1'b0;
        chk(mismatch === 1'b0, "R6", "mismatch cleared by accepted write", mismatch, 0);
        while (t < 900) begin
            if (t == 40 || t == 300) begin
                wr_req = 1'b1; rd_req = 1'b1; rst_req = 1'b1; sel_sec = 1'b1;
            end else begin
                wr_req = 1'b0; rd_req = 1'b0; rst_req = 1'b0;
            end
            if (!dev_pd_n) pd_lo++;
            if (done) dn++;
            @(negedge clk);
            t++;
        end
        sel_sec = 1'b0;
        chk(nfr - base == NREG, "R9", "frames with requests while busy", nfr - base, NREG);
        chk(pd_lo == 0, "R9", "power-down untouched", pd_lo, 0);
        chk(dn == 1, "R9", "done count", dn, 1);
        chk(frames[(base + 4) % 64] === {tv(1'b0, 4), 4'd4}, "R9", "write won, primary kept",
            frames[(base + 4) % 64], {tv(1'b0, 4), 4'd4});
        chk(busy === 1'b0, "R9", "idle at end", busy, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();                      // R1
        t_write(1'b0, 1);                     // R2 R3 R4 primary
        t_read(1'b0, 4'd0, 1, 1'b0, 1'b0);    // R5 R6
        t_read(1'b0, 4'd8, 2, 1'b0, 1'b0);    // R5
        t_write(1'b1, 3);                     // R2 R4 secondary, slow
        t_read(1'b1, 4'd5, 0, 1'b0, 1'b0);    // R4 divider 0
        t_read(1'b1, 4'd2, 1, 1'b1, 1'b1);    // R6 corrupted reply
        t_read(1'b1, 4'd7, 1, 1'b0, 1'b1);    // R6 sticky
        t_busy_ignore();                      // R9 R6
        t_reset_seq();                        // R7
        chk(rate_bad == 0, "R4", "sclk phase length errors", rate_bad, 0);
        chk(mosi_viol == 0, "R4", "mosi change with sclk high", mosi_viol, 0);
        chk(idle_viol == 0, "R1", "idle line violations", idle_viol, 0);
        summary();
        $finish;
    end

endmodule